// File: doc/BRIEF.md
# Serial Port Line-Rate Configuration Controller

This block holds the signaling-rate setting for a group of serial link ports that share one 156.25 MHz reference clock. Ports are paired: ports 2m and 2m+1 sit in the same MAC m. On reset every port takes its rate from one two-bit strap input, so all ports start at the same rate. After reset, software changes a port's rate through a small synchronous write interface. A change must follow a fixed order: power the port's lane group down, write the new code, then power it back up. Releasing power-down sends a one-cycle relock pulse to the downstream PHY.

Rate codes are 00 = 1.25 Gbit/s, 01 = 2.5 Gbit/s, 10 = 3.125 Gbit/s, and 11 = illegal. For each port the block reports its current code and its user bandwidth in single-lane and four-lane modes. A MAC that is switched to single-lane mode keeps both of its ports at one common rate. A combinational read port returns any port's status.

Top module: `lane_rate_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every port loads `strap_rate` as its rate code when that code is legal. Power-down, sequence-error, illegal and single-lane flags all clear.
- R2: A strap value of 11 at reset leaves every port at code 00 with its illegal flag set. No port ever reports code 11.
- R3: A rate write (`wr_sel`=01, code in `wr_data[1:0]`) to a powered-down port with a legal code is visible on `port_rate` in the cycle after the write edge.
- R4: A rate write to a port whose power-down bit is 0 leaves the rate unchanged and sets that port's sticky sequence-error flag.
- R5: A rate write of code 11 to a powered-down port leaves the rate unchanged and sets that port's sticky illegal flag.
- R6: A power-down write (`wr_sel`=00, value in `wr_data[0]`) that takes the bit from 1 to 0 raises `rate_apply` for that port for exactly the one cycle after the write edge. Writing 1, or writing 0 while already 0, gives no pulse.
- R7: When a MAC is in single-lane mode, an accepted rate write to either of its ports loads the same code into the partner port at the same edge.
- R8: A lane-mode write (`wr_sel`=10, `wr_data[0]`=1 for single-lane, addressed by either port index of the MAC) that selects single-lane mode also copies the even port's rate into the odd port.
- R9: User bandwidth is reported in units of 100 Mbit/s. Code 00 gives 10 (single-lane) and 40 (four-lane). Code 01 gives 20 and 80. Code 10 gives 25 and 100.
- R10: The read port returns the addressed port's rate, power-down bit, error flags and its MAC's single-lane bit combinationally. An index beyond the port count reads all zeros.
- R11: A write with `wr_sel`=11, or with an index at or beyond the port count, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_rate | input | 2 | Power-up default rate code for all ports |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 00 power-down, 01 rate, 10 lane mode, 11 none |
| wr_idx | input | IDX_W | Port index of the write |
| wr_data | input | 2 | Write value |
| rd_idx | input | IDX_W | Port index of the read |
| rd_rate | output | 2 | Rate code of the read port |
| rd_pdn | output | 1 | Power-down bit of the read port |
| rd_seq_err | output | 1 | Sticky sequence-error flag |
| rd_illegal | output | 1 | Sticky illegal-code flag |
| rd_single | output | 1 | Single-lane mode of the read port's MAC |
| port_rate | output | 2*NUM_PORTS | Rate code per port, port p at bits 2p+1:2p |
| rate_apply | output | NUM_PORTS | One-cycle relock pulse per port |
| bw_1x | output | 7*NUM_PORTS | Single-lane user bandwidth per port, 100 Mbit/s units |
| bw_4x | output | 7*NUM_PORTS | Four-lane user bandwidth per port, 100 Mbit/s units |

## Verification
All state sits in registers loaded at the write edge. Rate codes, flags, the lane mode and the `rate_apply` pulse therefore change exactly one cycle after the edge that samples a write. The bandwidth outputs and the read port follow the registered codes with no further delay. The bench applies each write, lets one rising edge pass, and compares every output against its behavioural model at the following falling edge. It sweeps `rd_idx` within that half cycle, so a result that arrives a cycle early or late is reported in the cycle it is due, and a pulse that lasts two cycles is caught on its second cycle.

// File: rtl/lrc_pkg.sv
`timescale 1ns/1ps
package lrc_pkg;

    localparam int BW_W = 7;

    typedef enum logic [1:0] {
        RATE_1G25  = 2'b00,
        RATE_2G5   = 2'b01,
        RATE_3G125 = 2'b10,
        RATE_BAD   = 2'b11
    } rate_code_e;

    typedef enum logic [1:0] {
        SEL_PDN  = 2'b00,
        SEL_RATE = 2'b01,
        SEL_MODE = 2'b10,
        SEL_NONE = 2'b11
    } wr_sel_e;

    typedef struct packed {
        logic [1:0] rate;
        logic       pdn;
        logic       seq_err;
        logic       illegal;
    } port_stat_t;

    function automatic logic code_legal(input logic [1:0] c);
        return c != RATE_BAD;
    endfunction

    function automatic logic [1:0] legal_or_base(input logic [1:0] c);
        return code_legal(c) ? c : RATE_1G25;
    endfunction

    // user bandwidth, 100 Mbit/s units, one lane
    function automatic logic [BW_W-1:0] bw_one_lane(input logic [1:0] c);
        logic [BW_W-1:0] r;
        unique case (c)
            RATE_1G25:  r = BW_W'(10);
            RATE_2G5:   r = BW_W'(20);
            RATE_3G125: r = BW_W'(25);
            default:    r = '0;
        endcase
        return r;
    endfunction

    // four lanes carry four times the single-lane payload
    function automatic logic [BW_W-1:0] bw_four_lane(input logic [1:0] c);
        return BW_W'({bw_one_lane(c), 2'b00});
    endfunction

endpackage

// File: rtl/lrc_wr_decode.sv
`timescale 1ns/1ps
module lrc_wr_decode
    import lrc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int IDX_W     = 2
) (
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [IDX_W-1:0]       wr_idx,
    output logic [NUM_PORTS-1:0]   pdn_we,
    output logic [NUM_PORTS-1:0]   rate_we,
    output logic [NUM_PORTS/2-1:0] mode_we
);
    localparam int NUM_MACS = NUM_PORTS / 2;

    logic [IDX_W-1:0] mac_idx;
    assign mac_idx = wr_idx >> 1;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit        = wr_en && (wr_idx == IDX_W'(p));
        assign pdn_we[p]  = hit && (wr_sel == SEL_PDN);
        assign rate_we[p] = hit && (wr_sel == SEL_RATE);
    end

    for (genvar m = 0; m < NUM_MACS; m++) begin : g_mac
        assign mode_we[m] = wr_en && (wr_sel == SEL_MODE)
                            && (mac_idx == IDX_W'(m));
    end

    // R11: one write reaches at most one target
    always_comb begin
        p_one_target_r11: assert ($onehot0({pdn_we, rate_we, mode_we}));
    end

endmodule

// File: rtl/lrc_mac_mode.sv
`timescale 1ns/1ps
module lrc_mac_mode (
    input  logic clk,
    input  logic rst,
    input  logic mode_we,
    input  logic mode_val,
    output logic mode_q,
    output logic force_sync
);
    always_ff @(posedge clk) begin
        if (rst)          mode_q <= 1'b0;
        else if (mode_we) mode_q <= mode_val;
    end

    // entering (or re-confirming) single-lane pulls the odd port to the even rate
    assign force_sync = mode_we & mode_val;

    p_mode_follows_r8: assert property (@(posedge clk) disable iff (rst)
        mode_we |=> (mode_q == $past(mode_val)));

    p_mode_holds_r11: assert property (@(posedge clk) disable iff (rst)
        !mode_we |=> $stable(mode_q));

endmodule

// File: rtl/lrc_port.sv
`timescale 1ns/1ps
module lrc_port
    import lrc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      strap,
    input  logic            pdn_we,
    input  logic            pdn_val,
    input  logic            rate_we,
    input  logic [1:0]      rate_val,
    input  logic            peer_load,
    input  logic [1:0]      peer_code,
    output port_stat_t      stat,
    output logic            apply,
    output logic            rate_accept,
    output logic [BW_W-1:0] bw_single,
    output logic [BW_W-1:0] bw_quad
);
    logic [1:0] rate_q;
    logic       pdn_q, seq_q, ill_q, apply_q;
    logic       wr_locked, wr_bad;

    assign wr_locked   = rate_we & ~pdn_q;
    assign wr_bad      = rate_we & pdn_q & ~code_legal(rate_val);
    assign rate_accept = rate_we & pdn_q & code_legal(rate_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q  <= legal_or_base(strap);
            ill_q   <= ~code_legal(strap);
            pdn_q   <= 1'b0;
            seq_q   <= 1'b0;
            apply_q <= 1'b0;
        end else begin
            if (rate_accept)    rate_q <= rate_val;
            else if (peer_load) rate_q <= peer_code;
            if (wr_locked) seq_q <= 1'b1;
            if (wr_bad)    ill_q <= 1'b1;
            if (pdn_we)    pdn_q <= pdn_val;
            apply_q <= pdn_we & ~pdn_val & pdn_q;
        end
    end

    assign stat.rate    = rate_q;
    assign stat.pdn     = pdn_q;
    assign stat.seq_err = seq_q;
    assign stat.illegal = ill_q;
    assign apply        = apply_q;
    assign bw_single    = bw_one_lane(rate_q);
    assign bw_quad      = bw_four_lane(rate_q);

    p_never_bad_code_r2: assert property (@(posedge clk) disable iff (rst)
        rate_q != RATE_BAD);

    p_locked_sets_err_r4: assert property (@(posedge clk) disable iff (rst)
        wr_locked |=> seq_q);

    p_locked_keeps_rate_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_locked && !peer_load) |=> $stable(rate_q));

    p_seq_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        seq_q |=> seq_q);

    p_bad_keeps_rate_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_bad && !peer_load) |=> ($stable(rate_q) && ill_q));

    p_accept_loads_r3: assert property (@(posedge clk) disable iff (rst)
        rate_accept |=> (rate_q == $past(rate_val)));

    p_apply_on_release_r6: assert property (@(posedge clk) disable iff (rst)
        apply_q |-> (!pdn_q && $past(pdn_q)));

    p_apply_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        apply_q |=> !apply_q);

endmodule

// File: rtl/lane_rate_ctrl.sv
`timescale 1ns/1ps
module lane_rate_ctrl
    import lrc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int IDX_W     = $clog2(NUM_PORTS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                strap_rate,
    input  logic                      wr_en,
    input  logic [1:0]                wr_sel,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [1:0]                wr_data,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [1:0]                rd_rate,
    output logic                      rd_pdn,
    output logic                      rd_seq_err,
    output logic                      rd_illegal,
    output logic                      rd_single,
    output logic [2*NUM_PORTS-1:0]    port_rate,
    output logic [NUM_PORTS-1:0]      rate_apply,
    output logic [BW_W*NUM_PORTS-1:0] bw_1x,
    output logic [BW_W*NUM_PORTS-1:0] bw_4x
);
    localparam int NUM_MACS = NUM_PORTS / 2;

    logic [NUM_PORTS-1:0] pdn_we, rate_we, accept, peer_load;
    logic [NUM_MACS-1:0]  mode_we, mode_q, force_sync;
    logic [1:0]           peer_code [NUM_PORTS];
    port_stat_t           stat      [NUM_PORTS];

    lrc_wr_decode #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_dec (
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_idx  (wr_idx),
        .pdn_we  (pdn_we),
        .rate_we (rate_we),
        .mode_we (mode_we)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        lrc_port u_port (
            .clk         (clk),
            .rst         (rst),
            .strap       (strap_rate),
            .pdn_we      (pdn_we[p]),
            .pdn_val     (wr_data[0]),
            .rate_we     (rate_we[p]),
            .rate_val    (wr_data),
            .peer_load   (peer_load[p]),
            .peer_code   (peer_code[p]),
            .stat        (stat[p]),
            .apply       (rate_apply[p]),
            .rate_accept (accept[p]),
            .bw_single   (bw_1x[p*BW_W +: BW_W]),
            .bw_quad     (bw_4x[p*BW_W +: BW_W])
        );
        assign port_rate[2*p +: 2] = stat[p].rate;
    end

    for (genvar m = 0; m < NUM_MACS; m++) begin : g_mac
        localparam int EV = 2 * m;
        localparam int OD = 2 * m + 1;

        lrc_mac_mode u_mode (
            .clk        (clk),
            .rst        (rst),
            .mode_we    (mode_we[m]),
            .mode_val   (wr_data[0]),
            .mode_q     (mode_q[m]),
            .force_sync (force_sync[m])
        );

        // single-lane pairing: an accepted write lands on both ports
        assign peer_load[EV] = mode_q[m] & accept[OD];
        assign peer_code[EV] = wr_data;
        assign peer_load[OD] = (mode_q[m] & accept[EV]) | force_sync[m];
        assign peer_code[OD] = force_sync[m] ? stat[EV].rate : wr_data;

        p_pair_same_rate_r7: assert property (@(posedge clk) disable iff (rst)
            mode_q[m] |-> (stat[EV].rate == stat[OD].rate));

        p_enter_single_sync_r8: assert property (@(posedge clk) disable iff (rst)
            force_sync[m] |=> (stat[OD].rate == $past(stat[EV].rate)));
    end

    always_comb begin
        rd_rate    = '0;
        rd_pdn     = 1'b0;
        rd_seq_err = 1'b0;
        rd_illegal = 1'b0;
        rd_single  = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_idx == IDX_W'(p)) begin
                rd_rate    = stat[p].rate;
                rd_pdn     = stat[p].pdn;
                rd_seq_err = stat[p].seq_err;
                rd_illegal = stat[p].illegal;
                rd_single  = mode_q[p/2];
            end
        end
    end

endmodule

// File: tb/lane_rate_ctrl_bench.sv
`timescale 1ns/1ps
module lane_rate_ctrl_bench;
    localparam int NP = 6;
    localparam int NM = NP / 2;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      strap_rate = 2'b00;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_sel = 2'b11;
    logic [IW-1:0]   wr_idx = '0;
    logic [1:0]      wr_data = '0;
    logic [IW-1:0]   rd_idx = '0;
    logic [1:0]      rd_rate;
    logic            rd_pdn, rd_seq_err, rd_illegal, rd_single;
    logic [2*NP-1:0] port_rate;
    logic [NP-1:0]   rate_apply;
    logic [7*NP-1:0] bw_1x, bw_4x;

    lane_rate_ctrl #(.NUM_PORTS(NP), .IDX_W(IW)) u_lane_rate_ctrl (
        .clk(clk), .rst(rst), .strap_rate(strap_rate),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_rate(rd_rate), .rd_pdn(rd_pdn),
        .rd_seq_err(rd_seq_err), .rd_illegal(rd_illegal), .rd_single(rd_single),
        .port_rate(port_rate), .rate_apply(rate_apply), .bw_1x(bw_1x), .bw_4x(bw_4x)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference state
    int m_rate [NP];
    int m_pdn  [NP];
    int m_seq  [NP];
    int m_ill  [NP];
    int m_app  [NP];
    int m_sgl  [NM];

    function automatic int exp_bw1(int c);
        if (c == 0) return 10;
        if (c == 1) return 20;
        if (c == 2) return 25;
        return 0;
    endfunction

    function automatic int exp_bw4(int c);
        if (c == 0) return 40;
        if (c == 1) return 80;
        if (c == 2) return 100;
        return 0;
    endfunction

    task automatic chk(int act, int exp, string tag, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int p = 0; p < NP; p++) begin
            chk(int'(port_rate[2*p +: 2]), m_rate[p], tag, $sformatf("port_rate[%0d]", p));
            chk(int'(rate_apply[p]), m_app[p], tag, $sformatf("rate_apply[%0d]", p));
            chk(int'(bw_1x[7*p +: 7]), exp_bw1(m_rate[p]), "R9", $sformatf("bw_1x[%0d]", p));
            chk(int'(bw_4x[7*p +: 7]), exp_bw4(m_rate[p]), "R9", $sformatf("bw_4x[%0d]", p));
        end
        for (int p = 0; p < NP; p++) begin
            rd_idx = IW'(p);
            #0.1;
            chk(int'(rd_rate), m_rate[p], "R10", $sformatf("rd_rate[%0d]", p));
            chk(int'(rd_pdn), m_pdn[p], tag, $sformatf("rd_pdn[%0d]", p));
            chk(int'(rd_seq_err), m_seq[p], tag, $sformatf("rd_seq_err[%0d]", p));
            chk(int'(rd_illegal), m_ill[p], tag, $sformatf("rd_illegal[%0d]", p));
            chk(int'(rd_single), m_sgl[p/2], tag, $sformatf("rd_single[%0d]", p));
        end
    endtask

    task automatic do_reset(logic [1:0] s, string tag);
        @(negedge clk);
        rst = 1'b1;
        strap_rate = s;
        wr_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int p = 0; p < NP; p++) begin
            m_rate[p] = (s == 2'b11) ? 0 : int'(s);
            m_ill[p]  = (s == 2'b11) ? 1 : 0;
            m_pdn[p]  = 0;
            m_seq[p]  = 0;
            m_app[p]  = 0;
        end
        for (int m = 0; m < NM; m++) m_sgl[m] = 0;
        check_all(tag);
    endtask

    // drive one write (or idle), advance one edge, compare at the next falling edge
    task automatic step(bit en, bit [1:0] sel, int idx, bit [1:0] dat, string tag);
        int n_rate [NP];
        int n_pdn  [NP];
        int n_seq  [NP];
        int n_ill  [NP];
        int n_app  [NP];
        int n_sgl  [NM];
        n_rate = m_rate; n_pdn = m_pdn; n_seq = m_seq; n_ill = m_ill; n_sgl = m_sgl;
        for (int p = 0; p < NP; p++) n_app[p] = 0;
        wr_en = en; wr_sel = sel; wr_idx = IW'(idx); wr_data = dat;
        if (en && idx < NP) begin
            if (sel == 2'b00) begin
                if (m_pdn[idx] == 1 && dat[0] == 1'b0) n_app[idx] = 1;
                n_pdn[idx] = int'(dat[0]);
            end else if (sel == 2'b01) begin
                if (m_pdn[idx] == 0) n_seq[idx] = 1;
                else if (dat == 2'b11) n_ill[idx] = 1;
                else begin
                    n_rate[idx] = int'(dat);
                    if (m_sgl[idx/2] == 1) n_rate[idx ^ 1] = int'(dat);
                end
            end else if (sel == 2'b10) begin
                n_sgl[idx/2] = int'(dat[0]);
                if (dat[0]) n_rate[(idx/2)*2 + 1] = m_rate[(idx/2)*2];
            end
        end
        @(posedge clk);
        m_rate = n_rate; m_pdn = n_pdn; m_seq = n_seq; m_ill = n_ill; m_app = n_app; m_sgl = n_sgl;
        @(negedge clk);
        wr_en = 1'b0;
        check_all(tag);
    endtask

    task automatic idle(string tag);
        step(1'b0, 2'b11, 0, 2'b00, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R2: illegal strap falls back to 00 with illegal flags set
        do_reset(2'b11, "R2");
        // R1: legal strap copied into every port
        do_reset(2'b10, "R1");
        do_reset(2'b01, "R1");

        // R4: write while powered up is rejected and flagged
        step(1'b1, 2'b01, 1, 2'b10, "R4");
        idle("R4");

        // R3: power down, write legal code
        step(1'b1, 2'b00, 0, 2'b01, "R6");
        step(1'b1, 2'b01, 0, 2'b10, "R3");
        step(1'b1, 2'b01, 0, 2'b00, "R3");
        // R5: illegal code leaves rate unchanged
        step(1'b1, 2'b01, 0, 2'b11, "R5");
        // R6: release gives one pulse
        step(1'b1, 2'b00, 0, 2'b00, "R6");
        idle("R6");
        step(1'b1, 2'b00, 0, 2'b00, "R6");
        step(1'b1, 2'b00, 4, 2'b01, "R6");
        step(1'b1, 2'b01, 4, 2'b10, "R3");
        step(1'b1, 2'b00, 4, 2'b00, "R6");

        // R8: make MAC1 ports differ, then enter single-lane through the odd index
        step(1'b1, 2'b00, 2, 2'b01, "R8");
        step(1'b1, 2'b01, 2, 2'b00, "R8");
        step(1'b1, 2'b10, 3, 2'b01, "R8");
        // R7: writes now land on both ports of MAC1
        step(1'b1, 2'b00, 3, 2'b01, "R7");
        step(1'b1, 2'b01, 3, 2'b10, "R7");
        step(1'b1, 2'b01, 2, 2'b01, "R7");
        // MAC0 stays four-lane: partner untouched
        step(1'b1, 2'b00, 1, 2'b01, "R7");
        step(1'b1, 2'b01, 1, 2'b00, "R7");
        // back to four-lane on MAC1, writes stay local
        step(1'b1, 2'b10, 2, 2'b00, "R8");
        step(1'b1, 2'b01, 2, 2'b00, "R7");

        // R11: ignored writes
        step(1'b1, 2'b11, 2, 2'b10, "R11");
        step(1'b1, 2'b01, 6, 2'b10, "R11");
        step(1'b1, 2'b00, 7, 2'b01, "R11");
        step(1'b1, 2'b10, 7, 2'b01, "R11");

        // R10: out-of-range read returns zeros
        rd_idx = IW'(7);
        #0.1;
        chk(int'({rd_rate, rd_pdn, rd_seq_err, rd_illegal, rd_single}), 0, "R10", "read idx 7");

        // release the remaining powered-down ports
        step(1'b1, 2'b00, 1, 2'b00, "R6");
        step(1'b1, 2'b00, 2, 2'b00, "R6");
        step(1'b1, 2'b00, 3, 2'b00, "R6");
        idle("R6");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule